// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This block keeps a calendar (second, minute, hour, day of week, day of month, month, year and century) in byte-wide registers. A processor-side byte port reads and writes them. Each field is coded either in packed BCD or in plain binary, chosen by a mode bit. The hour runs either over 0–23 or as 1–12 with a PM marker in bit 7. A one-second strobe (`sec_tick`) steps the calendar. A faster strobe (`rate_tick`) drives a programmable divider whose expiry raises the periodic event.

Four control/status bytes sit beside the time fields. Control A holds a rate code that sets the periodic divider. Control B holds the mode and enable bits. Status C collects the update, alarm and periodic event flags together with their OR. Status D reports valid contents. The registered `irq` output goes high in the cycle after any enabled source fires, and a read of status C clears it.

Register map, byte addresses: 0x0 seconds, 0x1 minutes, 0x2 hours, 0x3 day of week, 0x4 day of month, 0x5 month, 0x6 year, 0x7 century, 0x8 century mirror, 0x9 alarm seconds, 0xA alarm minutes, 0xB alarm hours, 0xC control A, 0xD control B, 0xE status C, 0xF status D.

Top module: `rtc_core`

## Requirements
- R1: After reset the registers read back as follows: seconds, minutes and hours 0x00; day of week, day of month and month 0x01; year 0x08; century and century mirror 0x20; all three alarm bytes 0x00; control A 0x26; control B 0x02; status C 0x00; status D 0x80. `irq` is low.
- R2: When control B bit 2 is 0 (BCD), each `sec_tick` steps the BCD seconds, with a nibble carry (0x09 goes to 0x10). Seconds wrap from 0x59 to 0x00 and carry into minutes. Minutes wrap from 0x59 the same way and carry into hours. In 24-hour mode (control B bit 1 = 1), hours wrap from 0x23 to 0x00 and carry into the date.
- R3: When control B bit 2 is 1 (binary), the same fields count in plain binary (9 goes to 10, which reads 0x0A). They wrap at 59, 59 and 23.
- R4: When control B bit 1 is 0 (12-hour mode), hours count 1–12 in bits 6:0, and bit 7 set means PM. 12 steps to 1 and keeps the marker. 11 steps to 12 and flips the marker. Only the step from 11 PM to 12 AM carries into the date.
- R5: A date carry steps the day of month. After the last day of the month it returns to 1 and carries into the month. February has 28 days; April, June, September and November have 30; all other months have 31. Month 12 returns to 1 and carries into the year. Year 99 returns to 0 and steps the century, and the new century value is also written to the century mirror.
- R6: A date carry steps the day of week through 0..6, where 6 returns to 0.
- R7: While control B bit 7 is 1, `sec_tick` changes no time field and sets no update or alarm flag.
- R8: When control B bit 5 is 1, an update whose resulting seconds, minutes and hours all equal the three alarm bytes sets status C bit 5.
- R9: For a control A rate code r in bits 3:0 that is not zero, status C bit 6 is set (when control B bit 6 is 1) on every 2^(r-1)-th `rate_tick`. A write to control A restarts this count. A rate code of 0 stops the periodic event.
- R10: Each update clears status C bits 6:4 before setting new flags. Bit 4 is then set when control B bit 4 is 1. Status C bit 7 reads as the OR of bits 6:4, and `irq` follows it one cycle after the event.
- R11: A read of status C returns its contents and then clears it. Writes to status C and status D are ignored, and status D always reads 0x80.
- R12: Events that coincide in one cycle combine: an update together with a periodic expiry leaves both flags set. A flag raised in the same cycle as a status C read survives the clear. A port write to a time field in a `sec_tick` cycle takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| rate_tick | input | 1 | One-cycle strobe at the periodic base rate |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request, registered |

## Verification
The calendar update and the periodic divider feed the same status byte, so the bench pulses `sec_tick` and `rate_tick` in the same cycle, with a divide-by-one rate and both enables set. It then expects status C to read 0xD0 rather than either flag alone. The bench also reads status C in the very cycle a periodic expiry lands. It expects the read to return the old cleared value, and the following read to show the new flag, because the set wins over the read-clear. A third collision drives a seconds write together with `sec_tick` and expects the written value rather than the stepped one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] A_SEC   = 4'h0;
  localparam logic [REG_AW-1:0] A_MIN   = 4'h1;
  localparam logic [REG_AW-1:0] A_HOUR  = 4'h2;
  localparam logic [REG_AW-1:0] A_WDAY  = 4'h3;
  localparam logic [REG_AW-1:0] A_MDAY  = 4'h4;
  localparam logic [REG_AW-1:0] A_MON   = 4'h5;
  localparam logic [REG_AW-1:0] A_YEAR  = 4'h6;
  localparam logic [REG_AW-1:0] A_CENT  = 4'h7;
  localparam logic [REG_AW-1:0] A_CENT2 = 4'h8;
  localparam logic [REG_AW-1:0] A_ASEC  = 4'h9;
  localparam logic [REG_AW-1:0] A_AMIN  = 4'hA;
  localparam logic [REG_AW-1:0] A_AHOUR = 4'hB;
  localparam logic [REG_AW-1:0] A_CTLA  = 4'hC;
  localparam logic [REG_AW-1:0] A_CTLB  = 4'hD;
  localparam logic [REG_AW-1:0] A_STC   = 4'hE;
  localparam logic [REG_AW-1:0] A_STD   = 4'hF;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
    logic [7:0] cent;
  } cal_t;

  // encode a small decimal constant in the active number format
  function automatic logic [7:0] enc(input int unsigned n, input logic bcd);
    logic [7:0] r;
    if (bcd) r = {4'(n / 10), 4'(n % 10)};
    else     r = 8'(n);
    return r;
  endfunction

  // add one in the active number format
  function automatic logic [7:0] inc(input logic [7:0] v, input logic bcd);
    logic [7:0] r;
    if (bcd && v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                       r = v + 8'd1;
    return r;
  endfunction

  function automatic logic [7:0] to_bin(input logic [7:0] v, input logic bcd);
    logic [7:0] r;
    if (bcd) r = ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    else     r = v;
    return r;
  endfunction

  function automatic int unsigned month_len(input logic [7:0] m);
    int unsigned r;
    case (m)
      8'd2:                      r = 28;
      8'd4, 8'd6, 8'd9, 8'd11:   r = 30;
      default:                   r = 31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_pkg::*;
(
  input  cal_t cur,
  input  logic bcd,
  input  logic h24,
  output cal_t nxt,
  output logic cent_step
);

  logic       sec_wrap;
  logic       min_wrap;
  logic       day_step;
  logic       mday_wrap;
  logic       mon_wrap;
  logic [7:0] hr;
  logic [7:0] hr_inc;
  logic [7:0] twelve;

  always_comb begin
    nxt       = cur;
    cent_step = 1'b0;
    day_step  = 1'b0;
    mday_wrap = 1'b0;
    mon_wrap  = 1'b0;
    hr        = {1'b0, cur.hour[6:0]};
    hr_inc    = inc(hr, bcd);
    twelve    = enc(12, bcd);

    sec_wrap = (cur.sec == enc(59, bcd));
    nxt.sec  = sec_wrap ? 8'h00 : inc(cur.sec, bcd);

    min_wrap = sec_wrap && (cur.min == enc(59, bcd));
    if (sec_wrap) nxt.min = (cur.min == enc(59, bcd)) ? 8'h00 : inc(cur.min, bcd);

    if (min_wrap) begin
      if (h24) begin
        if (cur.hour == enc(23, bcd)) begin
          nxt.hour = 8'h00;
          day_step = 1'b1;
        end else begin
          nxt.hour = inc(cur.hour, bcd);
        end
      end else begin
        if (hr == twelve) begin
          nxt.hour = {cur.hour[7], 7'd1};
        end else if (hr == enc(11, bcd)) begin
          nxt.hour = {~cur.hour[7], twelve[6:0]};
          day_step = cur.hour[7];
        end else begin
          nxt.hour = {cur.hour[7], hr_inc[6:0]};
        end
      end
    end

    if (day_step) begin
      nxt.wday  = (cur.wday == 8'd6) ? 8'd0 : cur.wday + 8'd1;
      mday_wrap = (cur.mday == enc(month_len(to_bin(cur.mon, bcd)), bcd));
      nxt.mday  = mday_wrap ? 8'd1 : inc(cur.mday, bcd);
      if (mday_wrap) begin
        mon_wrap = (cur.mon == enc(12, bcd));
        nxt.mon  = mon_wrap ? 8'd1 : inc(cur.mon, bcd);
      end
      if (mon_wrap) begin
        if (cur.year == enc(99, bcd)) begin
          nxt.year  = 8'h00;
          nxt.cent  = inc(cur.cent, bcd);
          cent_step = 1'b1;
        end else begin
          nxt.year = inc(cur.year, bcd);
        end
      end
    end
  end

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int RATE_W = 4,
  localparam int ACC_W = (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              hit
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   period;
  logic [ACC_W:0]   acc_nx;

  always_comb begin
    if (rate == '0) period = '0;
    else            period = (ACC_W+1)'(1) << (rate - RATE_W'(1));
    acc_nx = {1'b0, acc_q} + (ACC_W+1)'(1);
    hit    = tick && (rate != '0) && (acc_nx >= period);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) acc_q <= '0;
    else if (hit)       acc_q <= '0;
    else if (tick && rate != '0) acc_q <= acc_nx[ACC_W-1:0];
  end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              rate_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq
);

  cal_t       cal_q, cal_step, cal_n;
  logic [7:0] cent2_q, cent2_n;
  logic [7:0] asec_q, amin_q, ahour_q;
  logic [7:0] ctla_q, ctlb_q;
  logic [2:0] flg_q, flg_n;     // {periodic, alarm, update}
  logic       irq_q;
  logic [7:0] rdata_q;
  logic       cent_step;
  logic       per_hit;
  logic       upd;
  logic       alarm_hit;
  logic       rd_stc;
  logic       per_restart;

  rtc_cal_step u_step (
    .cur       (cal_q),
    .bcd       (~ctlb_q[2]),
    .h24       (ctlb_q[1]),
    .nxt       (cal_step),
    .cent_step (cent_step)
  );

  assign per_restart = wr_en && (addr == A_CTLA);

  rtc_periodic #(.RATE_W(RATE_W)) u_per (
    .clk     (clk),
    .rst     (rst),
    .tick    (rate_tick),
    .restart (per_restart),
    .rate    (ctla_q[RATE_W-1:0]),
    .hit     (per_hit)
  );

  always_comb begin
    upd       = sec_tick && !ctlb_q[7];
    cal_n     = upd ? cal_step : cal_q;
    cent2_n   = (upd && cent_step) ? cal_step.cent : cent2_q;
    alarm_hit = upd && ctlb_q[5] && (cal_step.sec == asec_q) &&
                (cal_step.min == amin_q) && (cal_step.hour == ahour_q);
    rd_stc    = rd_en && (addr == A_STC);
    flg_n     = flg_q;
    if (rd_stc || upd) flg_n = 3'b000;
    if (upd && ctlb_q[4]) flg_n[0] = 1'b1;
    if (alarm_hit)        flg_n[1] = 1'b1;
    if (per_hit && ctlb_q[6]) flg_n[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q   <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                   mday: 8'h01, mon: 8'h01, year: 8'h08, cent: 8'h20};
      cent2_q <= 8'h20;
      asec_q  <= 8'h00;
      amin_q  <= 8'h00;
      ahour_q <= 8'h00;
      ctla_q  <= 8'h26;
      ctlb_q  <= 8'h02;
      flg_q   <= 3'b000;
      irq_q   <= 1'b0;
    end else begin
      cal_q   <= cal_n;
      cent2_q <= cent2_n;
      flg_q   <= flg_n;
      irq_q   <= |flg_n;
      if (wr_en) begin
        case (addr)
          A_SEC:   cal_q.sec  <= wdata;
          A_MIN:   cal_q.min  <= wdata;
          A_HOUR:  cal_q.hour <= wdata;
          A_WDAY:  cal_q.wday <= wdata;
          A_MDAY:  cal_q.mday <= wdata;
          A_MON:   cal_q.mon  <= wdata;
          A_YEAR:  cal_q.year <= wdata;
          A_CENT:  cal_q.cent <= wdata;
          A_CENT2: cent2_q    <= wdata;
          A_ASEC:  asec_q     <= wdata;
          A_AMIN:  amin_q     <= wdata;
          A_AHOUR: ahour_q    <= wdata;
          A_CTLA:  ctla_q     <= wdata;
          A_CTLB:  ctlb_q     <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= 8'h00;
    end else if (rd_en) begin
      case (addr)
        A_SEC:   rdata_q <= cal_q.sec;
        A_MIN:   rdata_q <= cal_q.min;
        A_HOUR:  rdata_q <= cal_q.hour;
        A_WDAY:  rdata_q <= cal_q.wday;
        A_MDAY:  rdata_q <= cal_q.mday;
        A_MON:   rdata_q <= cal_q.mon;
        A_YEAR:  rdata_q <= cal_q.year;
        A_CENT:  rdata_q <= cal_q.cent;
        A_CENT2: rdata_q <= cent2_q;
        A_ASEC:  rdata_q <= asec_q;
        A_AMIN:  rdata_q <= amin_q;
        A_AHOUR: rdata_q <= ahour_q;
        A_CTLA:  rdata_q <= ctla_q;
        A_CTLB:  rdata_q <= ctlb_q;
        A_STC:   rdata_q <= {|flg_q, flg_q, 4'h0};
        default: rdata_q <= 8'h80;
      endcase
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic              rate_tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [REG_AW-1:0] addr,
  input logic [7:0]        rdata,
  input logic              irq,
  input logic [7:0]        ctlb,
  input logic [7:0]        sec_val
);

  AST_STATD_FIXED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STD) |=> (rdata == 8'h80));  // R11

  AST_SET_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (ctlb[7] && !wr_en) |=> $stable(sec_val));  // R7

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(sec_tick || rate_tick));  // R10

  AST_UPD_RAISES: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && ctlb[4] && !ctlb[7] && !wr_en) |=> irq);  // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STC && !sec_tick && !rate_tick) |=> !irq);  // R11

endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sec_tick  (sec_tick),
  .rate_tick (rate_tick),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .rdata     (rdata),
  .irq       (irq),
  .ctlb      (ctlb_q),
  .sec_val   (cal_q.sec)
);

// File: tb/rtc_core_test.sv
module rtc_core_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic       rate_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  rtc_core uut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .rate_tick(rate_tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic tick_sec();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic tick_rate(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rate_tick = 1'b1;
      @(negedge clk); rate_tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'h2, h); wr(4'h1, m); wr(4'h0, s);
  endtask

  task automatic t_reset();
    check("R1 irq", {7'd0, irq}, 8'h00);
    expect_reg("R1 sec", 4'h0, 8'h00);
    expect_reg("R1 min", 4'h1, 8'h00);
    expect_reg("R1 hour", 4'h2, 8'h00);
    expect_reg("R1 wday", 4'h3, 8'h01);
    expect_reg("R1 mday", 4'h4, 8'h01);
    expect_reg("R1 mon", 4'h5, 8'h01);
    expect_reg("R1 year", 4'h6, 8'h08);
    expect_reg("R1 cent", 4'h7, 8'h20);
    expect_reg("R1 cent2", 4'h8, 8'h20);
    expect_reg("R1 asec", 4'h9, 8'h00);
    expect_reg("R1 amin", 4'hA, 8'h00);
    expect_reg("R1 ahour", 4'hB, 8'h00);
    expect_reg("R1 ctla", 4'hC, 8'h26);
    expect_reg("R1 ctlb", 4'hD, 8'h02);
    expect_reg("R1 stc", 4'hE, 8'h00);
    expect_reg("R1 std", 4'hF, 8'h80);
  endtask

  task automatic t_bcd_roll();
    wr(4'hD, 8'h02);
    set_time(8'h00, 8'h00, 8'h09);
    tick_sec();
    expect_reg("R2 nibble carry", 4'h0, 8'h10);
    set_time(8'h23, 8'h59, 8'h59);
    wr(4'h4, 8'h31); wr(4'h5, 8'h12); wr(4'h6, 8'h99); wr(4'h3, 8'h06);
    tick_sec();
    expect_reg("R2 sec wrap", 4'h0, 8'h00);
    expect_reg("R2 min wrap", 4'h1, 8'h00);
    expect_reg("R2 hour wrap", 4'h2, 8'h00);
    expect_reg("R5 mday wrap", 4'h4, 8'h01);
    expect_reg("R5 mon wrap", 4'h5, 8'h01);
    expect_reg("R5 year wrap", 4'h6, 8'h00);
    expect_reg("R5 cent step", 4'h7, 8'h21);
    expect_reg("R5 cent mirror", 4'h8, 8'h21);
    expect_reg("R6 wday wrap", 4'h3, 8'h00);
  endtask

  task automatic t_feb();
    wr(4'hD, 8'h02);
    set_time(8'h23, 8'h59, 8'h59);
    wr(4'h4, 8'h28); wr(4'h5, 8'h02); wr(4'h3, 8'h02);
    tick_sec();
    expect_reg("R5 feb mday", 4'h4, 8'h01);
    expect_reg("R5 feb mon", 4'h5, 8'h03);
    expect_reg("R6 wday step", 4'h3, 8'h03);
  endtask

  task automatic t_binary();
    wr(4'hD, 8'h06);
    set_time(8'd0, 8'd0, 8'd9);
    tick_sec();
    expect_reg("R3 bin 9->10", 4'h0, 8'd10);
    set_time(8'd23, 8'd59, 8'd59);
    wr(4'h4, 8'd30); wr(4'h5, 8'd4);
    tick_sec();
    expect_reg("R3 bin sec", 4'h0, 8'd0);
    expect_reg("R3 bin hour", 4'h2, 8'd0);
    expect_reg("R5 bin 30-day mday", 4'h4, 8'd1);
    expect_reg("R5 bin mon", 4'h5, 8'd5);
    wr(4'hD, 8'h02);
  endtask

  task automatic t_12h();
    wr(4'hD, 8'h00);
    wr(4'h4, 8'h05); wr(4'h5, 8'h03);
    set_time(8'h91, 8'h59, 8'h59);
    tick_sec();
    expect_reg("R4 11PM->12AM", 4'h2, 8'h12);
    expect_reg("R4 day carry", 4'h4, 8'h06);
    set_time(8'h11, 8'h59, 8'h59);
    tick_sec();
    expect_reg("R4 11AM->12PM", 4'h2, 8'h92);
    expect_reg("R4 no day carry", 4'h4, 8'h06);
    set_time(8'h92, 8'h59, 8'h59);
    tick_sec();
    expect_reg("R4 12PM->1PM", 4'h2, 8'h81);
    wr(4'hD, 8'h02);
  endtask

  task automatic t_set();
    wr(4'hD, 8'h92);
    set_time(8'h00, 8'h00, 8'h10);
    tick_sec();
    expect_reg("R7 sec frozen", 4'h0, 8'h10);
    expect_reg("R7 no flag", 4'hE, 8'h00);
    wr(4'hD, 8'h02);
    tick_sec();
    expect_reg("R7 resumes", 4'h0, 8'h11);
  endtask

  task automatic t_update();
    wr(4'hD, 8'h12);
    tick_sec();
    check("R10 irq high", {7'd0, irq}, 8'h01);
    expect_reg("R10 update flag", 4'hE, 8'h90);
    check("R11 irq cleared", {7'd0, irq}, 8'h00);
    expect_reg("R11 cleared by read", 4'hE, 8'h00);
    tick_sec();
    wr(4'hD, 8'h02);
    tick_sec();
    expect_reg("R10 cleared at update", 4'hE, 8'h00);
  endtask

  task automatic t_alarm();
    wr(4'hD, 8'h22);
    set_time(8'h12, 8'h30, 8'h14);
    wr(4'h9, 8'h15); wr(4'hA, 8'h30); wr(4'hB, 8'h12);
    tick_sec();
    expect_reg("R8 alarm match", 4'hE, 8'hA0);
    tick_sec();
    expect_reg("R8 no match", 4'hE, 8'h00);
    wr(4'hD, 8'h02);
  endtask

  task automatic t_periodic();
    wr(4'hD, 8'h42);
    wr(4'hC, 8'h23);
    tick_rate(3);
    expect_reg("R9 before period", 4'hE, 8'h00);
    tick_rate(1);
    expect_reg("R9 at period", 4'hE, 8'hC0);
    wr(4'hC, 8'h20);
    tick_rate(8);
    expect_reg("R9 rate zero", 4'hE, 8'h00);
    wr(4'hD, 8'h02);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    wr(4'hD, 8'h52);
    wr(4'hC, 8'h21);
    rd(4'hE, v);
    @(negedge clk); sec_tick = 1'b1; rate_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0; rate_tick = 1'b0;
    expect_reg("R12 both flags", 4'hE, 8'hD0);
    @(negedge clk); rd_en = 1'b1; addr = 4'hE; rate_tick = 1'b1;
    @(negedge clk); rd_en = 1'b0; rate_tick = 1'b0;
    check("R12 read old value", rdata, 8'h00);
    expect_reg("R12 set beats clear", 4'hE, 8'hC0);
    wr(4'hD, 8'h02);
    wr(4'h0, 8'h20);
    @(negedge clk); sec_tick = 1'b1; wr_en = 1'b1; addr = 4'h0; wdata = 8'h40;
    @(negedge clk); sec_tick = 1'b0; wr_en = 1'b0;
    expect_reg("R12 write wins", 4'h0, 8'h40);
  endtask

  task automatic t_readonly();
    wr(4'hE, 8'hFF);
    wr(4'hF, 8'h00);
    expect_reg("R11 stc write ignored", 4'hE, 8'h00);
    expect_reg("R11 std fixed", 4'hF, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bcd_roll();
    t_feb();
    t_binary();
    t_12h();
    t_set();
    t_update();
    t_alarm();
    t_periodic();
    t_same_cycle();
    t_readonly();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule